// File: doc/BRIEF.md
# Multi-channel reference slew controller

This block holds a 5-bit reference code for each of four channels and walks each code, one LSB per step, toward one of two programmed target codes. The code maps linearly onto a voltage: code 0 stands for 0.3625 V and every step adds 12.5 mV, so code 31 is 0.75 V. A downstream DAC turns the code into the actual reference. The channels run on their own schedules. A code may move whether or not the regulator it feeds is switched on.

Software programs the block through a small register bank on a plain write/read bus. Each channel has two target registers and a 2-bit rate field. A shared control register holds, for each channel, a GO bit and a target-select bit. Setting GO only arms a channel. Motion starts when the `commit` strobe arrives; this strobe stands in for the end-of-transfer event of the serial bus engine. When a slew finishes, the hardware clears that channel's GO bit.

A `standby` level input overrides all of this. Its rising edge sends every channel toward its second target, and its falling edge sends every channel back to its first target. For each channel the block outputs the live code, a busy flag and a downward flag. The downward flag lets the regulator sink current. It also outputs a power-good qualifier that can be forced low while the channel ramps. The bus has no back-pressure: a write is taken in any cycle where `wr_en` is high, and a read is combinational. No port carries a stream, so there is no valid/ready handshake.

Top module: `ref_slew_ctrl`

## Requirements
- R1: After reset, every code is 25 (5'b11001), both target registers of every channel read 0x19, the control and rate registers read 0, and no channel is slewing.
- R2: The register map with NCH=4 is as follows. Address c (0..3) is channel c's first target, with bits [4:0] the code and bit 5 the power-good mask; it reads back as {mask, code} with bits 7:6 zero. Address 4+c is channel c's second target (code in [4:0]). Address 8 is the control register. Address 9 is the rate register.
- R3: Writing 1 to a GO bit does not move any code by itself. A `commit` pulse while a channel's GO bit is 0 leaves that channel idle.
- R4: A `commit` pulse launches every channel whose stored GO bit (control bit 2c) is 1. The channel heads toward its first target when the select bit (control bit 2c+1) is 0 and toward its second target when it is 1. The code then changes by exactly one LSB per step until it equals the target.
- R5: Rate field c (rate register bits [2c+1:2c]) set to 0, 1, 2 or 3 makes one step per 1, 2, 4 or 8 `tick` pulses. The code never changes in a cycle that does not follow a `tick`.
- R6: On the first `tick` that finds a busy channel's code equal to its target, `slewing_o[c]` drops and GO bit c reads 0. A channel that is already at its target when launched finishes on its first tick.
- R7: A rising edge on `standby` launches all channels toward their second target. A falling edge launches all channels toward their first target. Neither edge needs any GO bit.
- R8: `slew_dn_o[c]` is 1 exactly while channel c is busy and its code is above its target.
- R9: `pg_o[c]` equals `pg_in[c]` while channel c is idle. It also equals `pg_in[c]` while the channel is busy and its mask bit is 1. It is 0 while the channel is busy and its mask bit is 0. The mask resets to 0.
- R10: A launch that arrives while a channel is busy keeps the current code and heads toward the newly chosen target from there.
- R11: Channels launched together with different rates and targets progress independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Combinational read data |
| commit | input | 1 | Launch strobe for armed channels |
| standby | input | 1 | Standby level; its edges retarget all channels |
| tick | input | 1 | Timebase enable for stepping |
| pg_in | input | NCH | Raw power-good per channel |
| code_o | output | NCH*CODE_W | Current code per channel, channel c at [c*5 +: 5] |
| slewing_o | output | NCH | Channel busy |
| slew_dn_o | output | NCH | Channel busy and moving down |
| pg_o | output | NCH | Qualified power-good |

## Verification
The bench builds the block with its default NCH=4 and the package's 5-bit code and 2-bit rate fields. This gives all four rate settings at once, so two channels can run at 4 and 8 ticks per step beside a channel that is already at its target. With this size, a standby edge moves one channel eight codes while the other channels stand still or take two steps. A scoreboard holds, for each channel, the exact sequence of codes it expects. This catches skipped, doubled or wrong-direction steps, including when a slew is retargeted mid-ramp.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  localparam int CODE_W = 5;
  localparam int RATE_W = 2;
  localparam int MASK_BIT = CODE_W;
  localparam int CNT_W = (1 << RATE_W) - 1;
  localparam logic [CODE_W-1:0] RST_CODE = 5'b11001;

  typedef logic [CODE_W-1:0] code_t;

  typedef enum logic [RATE_W-1:0] {
    RATE_DIV1 = 2'd0,
    RATE_DIV2 = 2'd1,
    RATE_DIV4 = 2'd2,
    RATE_DIV8 = 2'd3
  } rate_e;
endpackage

// File: rtl/rsc_regs.sv
module rsc_regs
  import rsc_pkg::*;
#(
  parameter int NCH = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [DATA_W-1:0]        rd_data,
  input  logic [NCH-1:0]           go_clr,
  output logic [NCH*CODE_W-1:0]    tgt1_o,
  output logic [NCH*CODE_W-1:0]    tgt2_o,
  output logic [NCH-1:0]           mask_o,
  output logic [NCH-1:0]           go_o,
  output logic [NCH-1:0]           sel_o,
  output logic [NCH*RATE_W-1:0]    rate_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(2 * NCH);
  localparam logic [ADDR_W-1:0] A_RATE = ADDR_W'(2 * NCH + 1);

  code_t                 tgt1_q [NCH];
  code_t                 tgt2_q [NCH];
  logic [NCH-1:0]        mask_q;
  logic [NCH-1:0]        go_q;
  logic [NCH-1:0]        sel_q;
  logic [NCH*RATE_W-1:0] rate_q;
  logic [2*NCH-1:0]      ctrl_rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        tgt1_q[c] <= RST_CODE;
        tgt2_q[c] <= RST_CODE;
      end
      mask_q <= '0;
      go_q   <= '0;
      sel_q  <= '0;
      rate_q <= '0;
    end else begin
      // completion clears GO; a same-cycle write to the control register wins
      go_q <= go_q & ~go_clr;
      if (wr_en) begin
        for (int c = 0; c < NCH; c++) begin
          if (wr_addr == ADDR_W'(c)) begin
            tgt1_q[c] <= wr_data[CODE_W-1:0];
            mask_q[c] <= wr_data[MASK_BIT];
          end
          if (wr_addr == ADDR_W'(NCH + c)) begin
            tgt2_q[c] <= wr_data[CODE_W-1:0];
          end
        end
        if (wr_addr == A_CTRL) begin
          for (int c = 0; c < NCH; c++) begin
            go_q[c]  <= wr_data[2*c];
            sel_q[c] <= wr_data[2*c+1];
          end
        end
        if (wr_addr == A_RATE) begin
          rate_q <= wr_data[NCH*RATE_W-1:0];
        end
      end
    end
  end

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      ctrl_rd[2*c]   = go_q[c];
      ctrl_rd[2*c+1] = sel_q[c];
    end
  end

  always_comb begin
    rd_data = '0;
    for (int c = 0; c < NCH; c++) begin
      if (rd_addr == ADDR_W'(c)) rd_data = DATA_W'({mask_q[c], tgt1_q[c]});
      if (rd_addr == ADDR_W'(NCH + c)) rd_data = DATA_W'(tgt2_q[c]);
    end
    if (rd_addr == A_CTRL) rd_data = DATA_W'(ctrl_rd);
    if (rd_addr == A_RATE) rd_data = DATA_W'(rate_q);
  end

  for (genvar c = 0; c < NCH; c++) begin : g_flat
    assign tgt1_o[c*CODE_W +: CODE_W] = tgt1_q[c];
    assign tgt2_o[c*CODE_W +: CODE_W] = tgt2_q[c];
  end

  assign mask_o = mask_q;
  assign go_o   = go_q;
  assign sel_o  = sel_q;
  assign rate_o = rate_q;
endmodule

// File: rtl/rsc_launch.sv
module rsc_launch #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           commit,
  input  logic           standby,
  input  logic [NCH-1:0] go,
  input  logic [NCH-1:0] sel,
  output logic [NCH-1:0] launch,
  output logic [NCH-1:0] launch_sel
);
  logic stby_q;
  logic stby_rise;
  logic stby_fall;

  always_ff @(posedge clk) begin
    if (!rst_n) stby_q <= 1'b0;
    else        stby_q <= standby;
  end

  assign stby_rise = standby & ~stby_q;
  assign stby_fall = ~standby & stby_q;

  // standby edges outrank a commit in the same cycle
  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      if (stby_rise || stby_fall) begin
        launch[c]     = 1'b1;
        launch_sel[c] = stby_rise;
      end else begin
        launch[c]     = commit & go[c];
        launch_sel[c] = sel[c];
      end
    end
  end
endmodule

// File: rtl/rsc_chan.sv
module rsc_chan
  import rsc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              launch,
  input  logic              launch_sel,
  input  code_t             tgt1,
  input  code_t             tgt2,
  input  logic [RATE_W-1:0] rate,
  output code_t             code,
  output logic              busy,
  output logic              down,
  output logic              done
);
  logic             sel_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;
  code_t            tgt;
  logic             at_tgt;

  assign tgt    = sel_q ? tgt2 : tgt1;
  assign at_tgt = (code == tgt);

  always_comb begin
    unique case (rate_e'(rate))
      RATE_DIV1: lim = CNT_W'(0);
      RATE_DIV2: lim = CNT_W'(1);
      RATE_DIV4: lim = CNT_W'(3);
      default:   lim = CNT_W'(7);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code  <= RST_CODE;
      busy  <= 1'b0;
      sel_q <= 1'b0;
      cnt_q <= '0;
    end else if (launch) begin
      busy  <= 1'b1;
      sel_q <= launch_sel;
      cnt_q <= '0;
    end else if (busy && tick) begin
      if (at_tgt) begin
        busy  <= 1'b0;
        cnt_q <= '0;
      end else if (cnt_q == lim) begin
        cnt_q <= '0;
        code  <= (code > tgt) ? code - 1'b1 : code + 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign done = busy & tick & at_tgt & ~launch;
  assign down = busy & (code > tgt);
endmodule

// File: rtl/ref_slew_ctrl.sv
module ref_slew_ctrl
  import rsc_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DATA_W = 8,
  parameter int ADDR_W = $clog2(2 * NCH + 2)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [ADDR_W-1:0]     rd_addr,
  output logic [DATA_W-1:0]     rd_data,
  input  logic                  commit,
  input  logic                  standby,
  input  logic                  tick,
  input  logic [NCH-1:0]        pg_in,
  output logic [NCH*CODE_W-1:0] code_o,
  output logic [NCH-1:0]        slewing_o,
  output logic [NCH-1:0]        slew_dn_o,
  output logic [NCH-1:0]        pg_o
);
  logic [NCH*CODE_W-1:0] tgt1_w;
  logic [NCH*CODE_W-1:0] tgt2_w;
  logic [NCH-1:0]        mask_w;
  logic [NCH-1:0]        go_w;
  logic [NCH-1:0]        sel_w;
  logic [NCH*RATE_W-1:0] rate_w;
  logic [NCH-1:0]        done_w;
  logic [NCH-1:0]        launch_w;
  logic [NCH-1:0]        lsel_w;

  rsc_regs #(.NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .go_clr  (done_w),
    .tgt1_o  (tgt1_w),
    .tgt2_o  (tgt2_w),
    .mask_o  (mask_w),
    .go_o    (go_w),
    .sel_o   (sel_w),
    .rate_o  (rate_w)
  );

  rsc_launch #(.NCH(NCH)) u_launch (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit     (commit),
    .standby    (standby),
    .go         (go_w),
    .sel        (sel_w),
    .launch     (launch_w),
    .launch_sel (lsel_w)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    rsc_chan u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .launch     (launch_w[c]),
      .launch_sel (lsel_w[c]),
      .tgt1       (tgt1_w[c*CODE_W +: CODE_W]),
      .tgt2       (tgt2_w[c*CODE_W +: CODE_W]),
      .rate       (rate_w[c*RATE_W +: RATE_W]),
      .code       (code_o[c*CODE_W +: CODE_W]),
      .busy       (slewing_o[c]),
      .down       (slew_dn_o[c]),
      .done       (done_w[c])
    );
    assign pg_o[c] = pg_in[c] & (~slewing_o[c] | mask_w[c]);
  end
endmodule

// File: rtl/rsc_chk.sv
module rsc_chk #(
  parameter int NCH = 4,
  parameter int CODE_W = 5
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  tick,
  input logic                  wr_en,
  input logic [NCH*CODE_W-1:0] code_o,
  input logic [NCH-1:0]        slewing_o,
  input logic [NCH-1:0]        slew_dn_o,
  input logic [NCH-1:0]        pg_in,
  input logic [NCH-1:0]        pg_o,
  input logic [NCH-1:0]        go_bits
);
  for (genvar c = 0; c < NCH; c++) begin : g_c
    // R5
    code_only_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(tick) |-> $stable(code_o[c*CODE_W +: CODE_W]));

    // R4
    single_lsb_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(code_o[c*CODE_W +: CODE_W]) |->
        (code_o[c*CODE_W +: CODE_W] == CODE_W'($past(code_o[c*CODE_W +: CODE_W]) + 1'b1)) ||
        (code_o[c*CODE_W +: CODE_W] == CODE_W'($past(code_o[c*CODE_W +: CODE_W]) - 1'b1)));

    // R3
    idle_code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(slewing_o[c]) |-> $stable(code_o[c*CODE_W +: CODE_W]));

    // R6
    go_clear_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(slewing_o[c]) && !$past(wr_en)) |-> !go_bits[c]);

    // R8
    down_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slew_dn_o[c] |-> slewing_o[c]);

    // R9
    idle_pg_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !slewing_o[c] |-> (pg_o[c] == pg_in[c]));
  end
endmodule

bind ref_slew_ctrl rsc_chk #(.NCH(NCH), .CODE_W(rsc_pkg::CODE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .wr_en     (wr_en),
  .code_o    (code_o),
  .slewing_o (slewing_o),
  .slew_dn_o (slew_dn_o),
  .pg_in     (pg_in),
  .pg_o      (pg_o),
  .go_bits   (go_w)
);

// File: tb/ref_slew_ctrl_tb.sv
module ref_slew_ctrl_tb;
  localparam int NCH = 4;
  localparam int CW = 5;
  localparam int AW = 4;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic commit = 1'b0;
  logic standby = 1'b0;
  logic tick = 1'b0;
  logic [NCH-1:0] pg_in = '1;
  logic [NCH*CW-1:0] code_o;
  logic [NCH-1:0] slewing_o, slew_dn_o, pg_o;

  int nchk = 0;
  int nerr = 0;
  int cyc = 0;
  bit mon_on = 1'b0;
  int prev [NCH];
  int exp_q [NCH][$];

  always #4 clk = ~clk;

  ref_slew_ctrl #(.NCH(NCH)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .commit(commit), .standby(standby),
    .tick(tick), .pg_in(pg_in), .code_o(code_o), .slewing_o(slewing_o),
    .slew_dn_o(slew_dn_o), .pg_o(pg_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int code_of(input int c);
    return int'(code_o[c*CW +: CW]);
  endfunction

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = DW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    rd_addr = AW'(a);
    #1 d = int'(rd_data);
  endtask

  task automatic commit_p();
    @(negedge clk); commit = 1'b1;
    @(negedge clk); commit = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  // driver side of the scoreboard: expected code sequence for one ramp
  task automatic push_ramp(input int c, input int from, input int to);
    int v;
    v = from;
    while (v != to) begin
      v = (to > v) ? v + 1 : v - 1;
      exp_q[c].push_back(v);
    end
  endtask

  // monitor side: every code change must match the next expected item
  always @(negedge clk) begin
    int cur, e;
    if (mon_on) begin
      for (int c = 0; c < NCH; c++) begin
        cur = code_of(c);
        if (cur != prev[c]) begin
          if (exp_q[c].size() == 0) begin
            chk($sformatf("R4 unexpected step ch%0d", c), cur, prev[c]);
          end else begin
            e = exp_q[c].pop_front();
            chk($sformatf("R4 step ch%0d", c), cur, e);
          end
          prev[c] = cur;
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 20000);
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    int d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int c = 0; c < NCH; c++) prev[c] = code_of(c);
    mon_on = 1'b1;

    // R1 reset state
    for (int c = 0; c < NCH; c++) chk("R1 reset code", code_of(c), 25);
    chk("R1 reset slewing", int'(slewing_o), 0);
    rd(1, d); chk("R1 first target reset", d, 'h19);
    rd(6, d); chk("R1 second target reset", d, 'h19);
    rd(8, d); chk("R1 control reset", d, 0);
    rd(9, d); chk("R1 rate reset", d, 0);

    // R2 map and readback, upper bits dropped
    wr(0, 'hF4);
    rd(0, d); chk("R2 first target readback", d, 'h34);
    wr(4, 28);
    rd(4, d); chk("R2 second target readback", d, 28);

    // R3 GO alone does not move
    wr(8, 'h01);
    ticks(3);
    chk("R3 no motion before commit", code_of(0), 25);
    chk("R3 idle before commit", int'(slewing_o), 0);

    // R4/R5 rate 0, ch0 25 -> 20 downward, mask 1
    push_ramp(0, 25, 20);
    commit_p();
    chk("R4 launched", int'(slewing_o), 'b0001);
    chk("R8 down flag", int'(slew_dn_o), 'b0001);
    chk("R9 masked pg passes", int'(pg_o), 'hF);
    ticks(5);
    chk("R4 reached target", code_of(0), 20);
    chk("R6 busy until next tick", int'(slewing_o), 'b0001);
    ticks(1);
    chk("R6 done", int'(slewing_o), 0);
    rd(8, d); chk("R6 GO cleared", d, 0);

    // R5 rate 2 on ch1 upward to second target, mask 0
    wr(9, 'h08);
    wr(5, 27);
    wr(8, 'h0C);
    push_ramp(1, 25, 27);
    commit_p();
    chk("R9 pg forced low", int'(pg_o), 'b1101);
    chk("R8 no down when rising", int'(slew_dn_o), 0);
    ticks(3);
    chk("R5 div4 holds", code_of(1), 25);
    ticks(1);
    chk("R5 div4 steps", code_of(1), 26);
    ticks(4);
    chk("R5 div4 second step", code_of(1), 27);
    ticks(1);
    chk("R6 done ch1", int'(slewing_o), 0);
    rd(8, d); chk("R6 GO1 cleared sel kept", d, 'h08);

    // R11 ch2 at rate 3 beside ch3 already at target (R6)
    wr(2, 23);
    wr(7, 25);
    wr(9, 'h70);
    wr(8, 'hD0);
    commit_p();
    chk("R11 both launched", int'(slewing_o), 'b1100);
    ticks(1);
    chk("R6 at-target finishes on first tick", int'(slewing_o), 'b0100);
    rd(8, d); chk("R6 GO3 cleared", d, 'h90);
    ticks(6);
    chk("R5 div8 holds", code_of(2), 25);
    push_ramp(2, 25, 23);
    ticks(1);
    chk("R5 div8 steps", code_of(2), 24);
    ticks(8);
    chk("R11 ch2 reached", code_of(2), 23);
    ticks(1);
    chk("R11 ch2 done", int'(slewing_o), 0);
    rd(8, d); chk("R6 GO2 cleared", d, 'h80);

    // R7 standby rise to second targets
    wr(9, 0);
    push_ramp(0, 20, 28);
    push_ramp(2, 23, 25);
    @(negedge clk); standby = 1'b1;
    @(negedge clk);
    chk("R7 rise launches all", int'(slewing_o), 'hF);
    chk("R8 none down on rise", int'(slew_dn_o), 0);
    ticks(8);
    chk("R7 ch0 at second target", code_of(0), 28);
    ticks(1);
    chk("R7 rise all done", int'(slewing_o), 0);
    chk("R7 ch1 code", code_of(1), 27);
    chk("R7 ch2 code", code_of(2), 25);

    // R7 standby fall back to first targets
    push_ramp(0, 28, 20);
    push_ramp(1, 27, 25);
    push_ramp(2, 25, 23);
    @(negedge clk); standby = 1'b0;
    @(negedge clk);
    chk("R7 fall launches all", int'(slewing_o), 'hF);
    chk("R8 down flags on fall", int'(slew_dn_o), 'b0111);
    chk("R9 pg per mask on fall", int'(pg_o), 'b0001);
    ticks(9);
    chk("R7 fall all done", int'(slewing_o), 0);
    chk("R7 ch0 back", code_of(0), 20);

    // R10 retarget mid-slew
    wr(8, 'h03);
    push_ramp(0, 20, 23);
    commit_p();
    ticks(3);
    chk("R10 mid ramp code", code_of(0), 23);
    wr(8, 'h01);
    commit_p();
    chk("R10 code kept on retarget", code_of(0), 23);
    chk("R10 now heading down", int'(slew_dn_o), 'b0001);
    push_ramp(0, 23, 20);
    ticks(3);
    chk("R10 reached new target", code_of(0), 20);
    ticks(1);
    chk("R10 done", int'(slewing_o), 0);

    // R3 commit without GO, R9 idle pass-through
    wr(8, 'h02);
    commit_p();
    chk("R3 commit without GO idle", int'(slewing_o), 0);
    ticks(2);
    chk("R3 code held", code_of(0), 20);
    @(negedge clk); pg_in = 4'b1010;
    @(negedge clk);
    chk("R9 idle pg pass", int'(pg_o), 'b1010);

    for (int c = 0; c < NCH; c++) chk("R4 scoreboard drained", exp_q[c].size(), 0);

    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule